// File: doc/BRIEF.md
# Priority interrupt presentation controller

This block is the per-processor presentation stage of a two-level interrupt controller. A source controller offers it delivery requests, each a source number and a priority. The block keeps one request word that combines the processor's current priority with the number of the single pending source. It drives one interrupt line to the processor whenever a source is pending. It also holds a pending-priority byte and a software inter-processor interrupt (IPI) priority.

Software works the block through single-cycle register operations: accept, set current priority, set IPI priority and end-of-interrupt. A more favoured request displaces the pending one. Lowering the current priority can evict the pending request. Every displaced or refused external source goes back to the source controller as a reject, so that it can be presented again later.

A lower numeric priority is more favoured. The value 0xFF is the least favoured value and means "none". The request word holds the current priority in bits 31:24 and the pending source in bits 23:0. A source field of zero means nothing is pending.

Top module: `intp_presenter`

## Requirements
- R1: After reset the request word reads 0, the interrupt line is low, no notification is asserted, the IPI priority is 0xFF and the pending priority is 0xFF.
- R2: A delivery is refused when its priority is greater than or equal to the current priority, or when a source is pending whose priority is less than or equal to the incoming one. A refused delivery is returned one cycle later on the reject port with its own source number, and the request word is unchanged.
- R3: An accepted delivery loads its source into bits 23:0, records its priority as pending and raises the line. If the displaced source came from the source controller, it is rejected one cycle later. A displaced IPI is dropped without a reject.
- R4: Accept (op code 0) presents the whole request word on the accept-data port in the same cycle. After the edge, the word holds the old pending priority in bits 31:24 and 0 in bits 23:0, the pending priority is 0xFF and the line is low.
- R5: Set current priority (op code 1, value in data bits 7:0) writes bits 31:24. If the new value is lower than the old one and not above the pending priority, the pending source is cleared, the line drops, and an external source is rejected.
- R6: Set IPI priority (op code 2, value in data bits 7:0). The IPI is evaluated after op codes 1, 2 and 3. It is raised only when the IPI priority is below the current priority and no source is pending at a priority less than or equal to it. When raised, it sets the source field to 2 and the pending priority to the IPI priority, and it rejects a displaced external source.
- R7: End-of-interrupt (op code 3) copies data bits 31:24 into bits 31:24 of the request word. It forwards data bits 23:0 on the EOI port one cycle later when that field is nonzero.
- R8: One cycle after a set-current-priority or end-of-interrupt operation, the resend request is pulsed for one cycle.
- R9: A delivery presented in the same cycle as an operation strobe is not taken. The block instead pulses resend one cycle later and sends no reject for it.
- R10: A delivery with source number 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Delivery request strobe |
| req_src | input | 24 | Delivered source number |
| req_prio | input | 8 | Delivered priority |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 0 accept, 1 set current priority, 2 set IPI priority, 3 end-of-interrupt |
| op_data | input | 32 | Operation value |
| acc_data | output | 32 | Request word, valid as accept result in the accept cycle |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject notification strobe |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt notification strobe |
| eoi_src | output | 24 | Source number finished |
| resend_req | output | 1 | Request to all sources to present again |

## Verification
The arbitration rule is swept over a grid that crosses several current priorities with no pending source, a pending source at a favoured priority, and one at a less favoured priority. Each case is then offered an incoming priority from 0 to 9 and 0xFF. The sweep separates the refusals caused by the current priority from those caused by the pending priority, and it hits the equal-value edges of both. Directed sequences lower the current priority to just above, equal to and below a pending priority, and move the IPI priority across the pending and current priorities. They also check accept and end-of-interrupt round trips, and deliveries that coincide with an operation or carry source 0.

// File: rtl/intp_presenter.sv
module intp_presenter #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [SRC_W-1:0]        req_src,
  input  logic [PRIO_W-1:0]       req_prio,
  input  logic                    op_valid,
  input  logic [1:0]              op_code,
  input  logic [PRIO_W+SRC_W-1:0] op_data,
  output logic [PRIO_W+SRC_W-1:0] acc_data,
  output logic                    irq_out,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    resend_req
);
  localparam logic [PRIO_W-1:0] NONE = '1;
  localparam logic [SRC_W-1:0]  IPI  = SRC_W'(IPI_NUM);
  localparam logic [1:0] OP_ACC = 2'd0, OP_CPPR = 2'd1, OP_MFRR = 2'd2, OP_EOI = 2'd3;

  logic [PRIO_W-1:0] cppr, pend_prio, ipi_prio;
  logic [SRC_W-1:0]  pend_src;
  logic              pend_ext;

  logic [PRIO_W-1:0] n_cppr, n_pp, n_ipi;
  logic [SRC_W-1:0]  n_src, n_rej_src, n_eoi_src;
  logic              n_ext, n_rej, n_eoi, n_res, ipi_chk;

  assign acc_data = {cppr, pend_src};

  always_comb begin
    n_cppr = cppr; n_pp = pend_prio; n_ipi = ipi_prio; n_src = pend_src; n_ext = pend_ext;
    n_rej = 1'b0; n_rej_src = '0; n_eoi = 1'b0; n_eoi_src = '0; n_res = 1'b0; ipi_chk = 1'b0;
    if (op_valid) begin
      if (req_valid && req_src != '0) n_res = 1'b1;
      case (op_code)
        OP_ACC: begin
          n_cppr = pend_prio; n_src = '0; n_pp = NONE; n_ext = 1'b0;
        end
        OP_CPPR: begin
          n_cppr = op_data[PRIO_W-1:0];
          if (n_cppr < cppr && pend_src != '0 && n_cppr <= pend_prio) begin
            n_rej = pend_ext; n_rej_src = pend_ext ? pend_src : '0;
            n_src = '0; n_pp = NONE; n_ext = 1'b0;
          end
          n_res = 1'b1; ipi_chk = 1'b1;
        end
        OP_MFRR: begin
          n_ipi = op_data[PRIO_W-1:0]; ipi_chk = 1'b1;
        end
        default: begin
          n_cppr = op_data[PRIO_W+SRC_W-1:SRC_W];
          if (op_data[SRC_W-1:0] != '0) begin
            n_eoi = 1'b1; n_eoi_src = op_data[SRC_W-1:0];
          end
          n_res = 1'b1; ipi_chk = 1'b1;
        end
      endcase
    end else if (req_valid && req_src != '0) begin
      if (req_prio >= cppr || (pend_src != '0 && pend_prio <= req_prio)) begin
        n_rej = 1'b1; n_rej_src = req_src;
      end else begin
        if (pend_src != '0 && pend_ext) begin
          n_rej = 1'b1; n_rej_src = pend_src;
        end
        n_src = req_src; n_pp = req_prio; n_ext = 1'b1;
      end
    end
    if (ipi_chk && n_ipi < n_cppr && !(n_src != '0 && n_pp <= n_ipi)) begin
      if (n_src != '0 && n_ext) begin
        n_rej = 1'b1; n_rej_src = n_src;
      end
      n_src = IPI; n_pp = n_ipi; n_ext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr <= '0; pend_src <= '0; pend_prio <= NONE; ipi_prio <= NONE; pend_ext <= 1'b0;
      irq_out <= 1'b0; rej_valid <= 1'b0; rej_src <= '0;
      eoi_valid <= 1'b0; eoi_src <= '0; resend_req <= 1'b0;
    end else begin
      cppr <= n_cppr; pend_src <= n_src; pend_prio <= n_pp; ipi_prio <= n_ipi; pend_ext <= n_ext;
      irq_out <= n_src != '0;
      rej_valid <= n_rej; rej_src <= n_rej_src;
      eoi_valid <= n_eoi; eoi_src <= n_eoi_src; resend_req <= n_res;
    end
  end

  AST_LINE_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (acc_data[SRC_W-1:0] != '0)); // R3
  AST_PEND_HAS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_src == '0) == (pend_prio == NONE)); // R4
  AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_ACC |=> !irq_out && acc_data[SRC_W-1:0] == '0); // R4
  AST_REJ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> rej_src != '0); // R2
  AST_RESEND_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_CPPR || op_code == OP_EOI) |=> resend_req); // R8
  AST_EOI_CPPR: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_EOI |=> acc_data[PRIO_W+SRC_W-1:SRC_W] == $past(op_data[PRIO_W+SRC_W-1:SRC_W])); // R7
  AST_ZERO_SRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && req_valid && req_src == '0 |=> $stable(acc_data) && !rej_valid); // R10
endmodule

// File: tb/intp_presenter_tb.sv
module intp_presenter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, op_valid = 1'b0;
  logic [23:0] req_src = '0;
  logic [7:0] req_prio = '0;
  logic [1:0] op_code = '0;
  logic [31:0] op_data = '0;
  logic [31:0] acc_data;
  logic irq_out, rej_valid, eoi_valid, resend_req;
  logic [23:0] rej_src, eoi_src;

  int checks = 0, fails = 0;

  logic [7:0] m_cppr, m_pp, m_mfrr;
  logic [23:0] m_src;
  bit m_ext, e_rej, e_eoi, e_res;
  logic [23:0] e_rej_src, e_eoi_src;

  always #4 clk = ~clk;

  intp_presenter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .op_valid(op_valid), .op_code(op_code), .op_data(op_data), .acc_data(acc_data),
    .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src), .eoi_valid(eoi_valid),
    .eoi_src(eoi_src), .resend_req(resend_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input bit ov, input logic [1:0] oc, input logic [31:0] od,
                       input bit rv, input logic [23:0] rs, input logic [7:0] rp);
    bit ipi = 0;
    e_rej = 0; e_rej_src = '0; e_eoi = 0; e_eoi_src = '0; e_res = 0;
    if (ov) begin
      if (rv && rs != 0) e_res = 1;
      if (oc == 0) begin
        m_cppr = m_pp; m_src = 0; m_pp = 8'hFF; m_ext = 0;
      end else if (oc == 1) begin
        if (od[7:0] < m_cppr && m_src != 0 && od[7:0] <= m_pp) begin
          if (m_ext) begin e_rej = 1; e_rej_src = m_src; end
          m_src = 0; m_pp = 8'hFF; m_ext = 0;
        end
        m_cppr = od[7:0]; e_res = 1; ipi = 1;
      end else if (oc == 2) begin
        m_mfrr = od[7:0]; ipi = 1;
      end else begin
        m_cppr = od[31:24];
        if (od[23:0] != 0) begin e_eoi = 1; e_eoi_src = od[23:0]; end
        e_res = 1; ipi = 1;
      end
    end else if (rv && rs != 0) begin
      if (rp >= m_cppr || (m_src != 0 && m_pp <= rp)) begin
        e_rej = 1; e_rej_src = rs;
      end else begin
        if (m_src != 0 && m_ext) begin e_rej = 1; e_rej_src = m_src; end
        m_src = rs; m_pp = rp; m_ext = 1;
      end
    end
    if (ipi && m_mfrr < m_cppr && !(m_src != 0 && m_pp <= m_mfrr)) begin
      if (m_src != 0 && m_ext) begin e_rej = 1; e_rej_src = m_src; end
      m_src = 24'd2; m_pp = m_mfrr; m_ext = 0;
    end
  endtask

  task automatic step(input string tag, input bit ov, input logic [1:0] oc, input logic [31:0] od,
                      input bit rv, input logic [23:0] rs, input logic [7:0] rp);
    logic [31:0] old = {m_cppr, m_src};
    op_valid = ov; op_code = oc; op_data = od; req_valid = rv; req_src = rs; req_prio = rp;
    model(ov, oc, od, rv, rs, rp);
    #1;
    if (ov && oc == 0) chk("R4 accept value", acc_data, old);
    @(negedge clk);
    op_valid = 0; req_valid = 0;
    chk({tag, " word"}, acc_data, {m_cppr, m_src});
    chk({tag, " line"}, 32'(irq_out), 32'(m_src != 0));
    chk({tag, " reject"}, {7'd0, rej_valid, rej_src}, {7'd0, e_rej, e_rej_src});
    chk({tag, " eoi"}, {7'd0, eoi_valid, eoi_src}, {7'd0, e_eoi, e_eoi_src});
    chk({tag, " resend"}, 32'(resend_req), 32'(e_res));
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_cppr = 0; m_pp = 8'hFF; m_mfrr = 8'hFF; m_src = 0; m_ext = 0;
  endtask

  task automatic deliver(input string tag, input logic [23:0] s, input logic [7:0] p);
    step(tag, 0, 0, 0, 1, s, p);
  endtask

  task automatic op(input string tag, input logic [1:0] c, input logic [31:0] d);
    step(tag, 1, c, d, 0, 0, 0);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] cv[4] = '{8'h00, 8'h03, 8'h07, 8'hFF};
    logic [7:0] pv[3] = '{8'h00, 8'h02, 8'h05};
    @(negedge clk);
    do_reset();
    chk("R1 word", acc_data, 0);
    chk("R1 line", 32'(irq_out), 0);
    chk("R1 notify", {29'd0, rej_valid, eoi_valid, resend_req}, 0);
    op("R1 pending none via accept", 0, 0);
    op("R1 ipi none", 1, 32'hFF);

    for (int ci = 0; ci < 4; ci++)
      for (int pi = 0; pi < 3; pi++)
        for (int q = 0; q < 11; q++) begin
          do_reset();
          op("R5 setup", 1, {24'd0, cv[ci]});
          if (pi != 0) deliver("R3 first", 24'h100, pv[pi]);
          deliver((q == 10 || q >= cv[ci] || (pi != 0 && pv[pi] <= q)) ? "R2 sweep" : "R3 sweep",
                  24'h200, q == 10 ? 8'hFF : 8'(q));
        end

    for (int nv = 0; nv < 9; nv++) begin
      do_reset();
      op("R5 open", 1, 32'hFF);
      deliver("R3 pend", 24'h44, 8'd6);
      op("R5 lower", 1, 32'(nv));
    end

    do_reset();
    op("R5 open", 1, 32'hFF);
    deliver("R3 pend", 24'h33, 8'd4);
    op("R4 accept", 0, 0);
    op("R7 eoi", 3, 32'hFF00_0033);
    op("R7 eoi empty", 3, 32'h8000_0000);

    do_reset();
    op("R5 open", 1, 32'hFF);
    op("R6 raise", 2, 32'd5);
    deliver("R3 over ipi", 24'h55, 8'd3);
    op("R6 held", 2, 32'd4);
    op("R6 held equal", 2, 32'd3);
    op("R6 displace", 2, 32'd1);
    op("R4 accept ipi", 0, 0);
    op("R6 none", 2, 32'hFF);
    op("R6 not below", 1, 32'hFF);
    op("R6 equal cppr", 2, 32'hFF);

    do_reset();
    op("R5 open", 1, 32'hFF);
    step("R9 coincide", 1, 2, 32'hFF, 1, 24'h66, 8'd1);
    step("R9 coincide acc", 1, 0, 0, 1, 24'h67, 8'd1);
    deliver("R10 zero", 24'd0, 8'd1);
    deliver("R3 after", 24'h68, 8'd2);
    step("R10 zero keep", 0, 0, 0, 1, 24'd0, 8'd0);
    op("R8 eoi resend", 3, 32'h0500_0068);
    op("R8 cppr resend", 1, 32'h07);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule